// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns a decoded memory-operand description into the 20-bit physical address used by a 16-bit segmented processor. Each request carries an addressing-mode code, a pointer selection, a displacement of 8 or 16 bits, and the current values of the four pointer registers (base BX, base pointer BP, source index SI, destination index DI) and the four segment registers. The block forms a 16-bit offset from those values and picks a segment register. The segment is either the default for the mode or the one named by a valid override. The physical address is the segment value shifted left by four bits plus the offset.

Requests arrive with a valid strobe. The result appears on the registered outputs one clock later, and it holds while no request is presented. Register and immediate operand modes do not refer to memory. For these the block clears its memory-operand flag and returns zero address fields, so the memory access can be skipped downstream.

Top module: `ea_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `out_valid`, `mem_op`, `offset`, `seg_used` and `phys_addr` are all zero.
- R2: A request sampled with `in_valid`=1 at a rising edge shows its result, with `out_valid`=1, after that edge. A cycle with `in_valid`=0 gives `out_valid`=0 and leaves `mem_op`, `offset`, `seg_used` and `phys_addr` unchanged.
- R3: Mode codes 0 (register operand), 1 (immediate operand) and 7 (reserved) are not memory operands. For these, `mem_op`=0 and `offset`, `seg_used` and `phys_addr` are all zero. Every other mode gives `mem_op`=1.
- R4: Mode 2 (direct) uses the full 16-bit `disp` as the offset and defaults to DS.
- R5: Mode 3 (register indirect) uses the register chosen by `ptr_sel` as the offset, with 0=BX, 1=BP, 2=SI and 3=DI. The default segment is SS when BP is chosen and DS otherwise. The displacement is ignored.
- R6: Mode 4 (one register plus displacement) adds the register chosen by `ptr_sel` (same codes as R5) to the displacement, with the same default segment as R5. `disp_sz` sets the displacement: 0 means none, 1 means `disp[7:0]` sign-extended to 16 bits, and 2 or 3 means the full 16-bit `disp`.
- R7: Mode 5 (based-indexed) adds a base register and an index register to the displacement chosen by `disp_sz` (as in R6). The base is chosen by `ptr_sel[0]` (0=BX, 1=BP) and the index by `ptr_sel[1]` (0=SI, 1=DI). The default segment is SS when the base is BP and DS otherwise.
- R8: Mode 6 (string destination) uses DI as the offset and always uses ES, even when an override is valid. The displacement is ignored.
- R9: In modes 2 to 5, `ovr_valid`=1 replaces the default segment with the one coded on `ovr_seg`. The segment codes, shared with `seg_used`, are 0=ES, 1=CS, 2=SS and 3=DS.
- R10: All offset sums wrap modulo 2^16. For example, BX=FFFF plus SI=0002 gives offset 0001.
- R11: `phys_addr` equals (segment value × 16 + offset) modulo 2^20. For example, segment FFFF with offset 0010 gives 00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 3 | Addressing-mode code |
| ptr_sel | input | 2 | Pointer register selection |
| disp_sz | input | 2 | Displacement size code |
| disp | input | 16 | Displacement or direct offset |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 2 | Override segment code |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | ES value |
| seg_cs | input | 16 | CS value |
| seg_ss | input | 16 | SS value |
| seg_ds | input | 16 | DS value |
| out_valid | output | 1 | Result valid |
| mem_op | output | 1 | Operand resides in memory |
| offset | output | 16 | Effective offset |
| seg_used | output | 2 | Segment code applied |
| phys_addr | output | 20 | Physical address |

## Verification
Each output is a single register stage over combinational logic. A wrong pointer choice, a wrong sign extension or a wrong segment choice therefore shows on `offset`, `seg_used` or `phys_addr` on the first clock after the request that triggers it. The main risk is the interaction of modes: BP-based defaults versus overrides, an override that the string destination must ignore, and 8-bit displacements with the sign bit set. For that reason, cycles with directed stimulus and with random stimulus are each compared, field by field, against an independent model.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    M_REG  = 3'd0,
    M_IMM  = 3'd1,
    M_DIR  = 3'd2,
    M_RIND = 3'd3,
    M_RDSP = 3'd4,
    M_BIDX = 3'd5,
    M_SDST = 3'd6,
    M_RSV  = 3'd7
  } ea_mode_e;

  typedef enum logic [1:0] {
    SG_ES = 2'd0,
    SG_CS = 2'd1,
    SG_SS = 2'd2,
    SG_DS = 2'd3
  } ea_seg_e;

  localparam int unsigned NUM_SEG = 4;
endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
  import ea_pkg::*;
#(
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned DSP8_W = 8
) (
  input  logic [2:0]       mode,
  input  logic [1:0]       ptr_sel,
  input  logic [1:0]       disp_sz,
  input  logic [OFF_W-1:0] disp,
  input  logic [OFF_W-1:0] reg_bx,
  input  logic [OFF_W-1:0] reg_bp,
  input  logic [OFF_W-1:0] reg_si,
  input  logic [OFF_W-1:0] reg_di,
  output logic [OFF_W-1:0] offset,
  output logic             uses_bp,
  output logic             is_mem
);
  localparam int unsigned EXT_W = OFF_W - DSP8_W;

  logic [OFF_W-1:0] disp_ext;
  logic [OFF_W-1:0] single_reg;
  logic [OFF_W-1:0] base_reg;
  logic [OFF_W-1:0] idx_reg;
  ea_mode_e         mode_e;

  assign mode_e = ea_mode_e'(mode);

  always_comb begin
    unique case (disp_sz)
      2'd0:    disp_ext = '0;
      2'd1:    disp_ext = {{EXT_W{disp[DSP8_W-1]}}, disp[DSP8_W-1:0]};
      default: disp_ext = disp;
    endcase
  end

  always_comb begin
    unique case (ptr_sel)
      2'd0:    single_reg = reg_bx;
      2'd1:    single_reg = reg_bp;
      2'd2:    single_reg = reg_si;
      default: single_reg = reg_di;
    endcase
    base_reg = ptr_sel[0] ? reg_bp : reg_bx;
    idx_reg  = ptr_sel[1] ? reg_di : reg_si;
  end

  always_comb begin
    offset  = '0;
    uses_bp = 1'b0;
    is_mem  = 1'b1;
    unique case (mode_e)
      M_DIR:  offset = disp;
      M_RIND: begin
        offset  = single_reg;
        uses_bp = (ptr_sel == 2'd1);
      end
      M_RDSP: begin
        offset  = single_reg + disp_ext;
        uses_bp = (ptr_sel == 2'd1);
      end
      M_BIDX: begin
        offset  = base_reg + idx_reg + disp_ext;
        uses_bp = ptr_sel[0];
      end
      M_SDST: offset = reg_di;
      default: is_mem = 1'b0;
    endcase
  end
endmodule

// File: rtl/ea_seg_select.sv
module ea_seg_select
  import ea_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  logic [2:0]                      mode,
  input  logic                            uses_bp,
  input  logic                            ovr_valid,
  input  logic [1:0]                      ovr_seg,
  input  logic [NUM_SEG-1:0][SEG_W-1:0]   seg_bank,
  output logic [1:0]                      seg_code,
  output logic [SEG_W-1:0]                seg_val
);
  ea_mode_e mode_e;
  ea_seg_e  dflt;
  logic     ovr_ok;

  assign mode_e = ea_mode_e'(mode);

  always_comb begin
    dflt   = uses_bp ? SG_SS : SG_DS;
    ovr_ok = 1'b0;
    unique case (mode_e)
      M_DIR, M_RIND, M_RDSP, M_BIDX: ovr_ok = ovr_valid;
      M_SDST:  dflt = SG_ES;
      default: ;
    endcase
    seg_code = ovr_ok ? ovr_seg : dflt;
    seg_val  = seg_bank[seg_code];
  end
endmodule

// File: rtl/ea_phys_add.sv
module ea_phys_add #(
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SEG_W = 16,
  parameter int unsigned SHIFT = 4,
  parameter int unsigned PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg_val,
  input  logic [OFF_W-1:0] offset,
  output logic [PA_W-1:0]  phys
);
  localparam int unsigned SUM_W = ((SEG_W + SHIFT) > OFF_W ? (SEG_W + SHIFT) : OFF_W) + 1;

  logic [SUM_W-1:0] seg_sh;
  logic [SUM_W-1:0] sum;

  assign seg_sh = SUM_W'(seg_val) << SHIFT;
  assign sum    = seg_sh + SUM_W'(offset);
  assign phys   = sum[PA_W-1:0];
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SEG_W = 16,
  parameter int unsigned SHIFT = 4,
  parameter int unsigned PA_W  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       mode,
  input  logic [1:0]       ptr_sel,
  input  logic [1:0]       disp_sz,
  input  logic [OFF_W-1:0] disp,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_seg,
  input  logic [OFF_W-1:0] reg_bx,
  input  logic [OFF_W-1:0] reg_bp,
  input  logic [OFF_W-1:0] reg_si,
  input  logic [OFF_W-1:0] reg_di,
  input  logic [SEG_W-1:0] seg_es,
  input  logic [SEG_W-1:0] seg_cs,
  input  logic [SEG_W-1:0] seg_ss,
  input  logic [SEG_W-1:0] seg_ds,
  output logic             out_valid,
  output logic             mem_op,
  output logic [OFF_W-1:0] offset,
  output logic [1:0]       seg_used,
  output logic [PA_W-1:0]  phys_addr
);
  logic [OFF_W-1:0]                   off_c;
  logic                               bp_c;
  logic                               mem_c;
  logic [NUM_SEG-1:0][SEG_W-1:0]      bank;
  logic [1:0]                         code_c;
  logic [SEG_W-1:0]                   sval_c;
  logic [PA_W-1:0]                    pa_c;

  logic             valid_d;
  logic             mem_d;
  logic [OFF_W-1:0] off_d;
  logic [1:0]       seg_d;
  logic [PA_W-1:0]  pa_d;

  assign bank = {seg_ds, seg_ss, seg_cs, seg_es};

  ea_offset_calc #(.OFF_W(OFF_W), .DSP8_W(8)) u_off (
    .mode(mode), .ptr_sel(ptr_sel), .disp_sz(disp_sz), .disp(disp),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .offset(off_c), .uses_bp(bp_c), .is_mem(mem_c)
  );

  ea_seg_select #(.SEG_W(SEG_W)) u_seg (
    .mode(mode), .uses_bp(bp_c), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .seg_bank(bank), .seg_code(code_c), .seg_val(sval_c)
  );

  ea_phys_add #(.OFF_W(OFF_W), .SEG_W(SEG_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_pa (
    .seg_val(sval_c), .offset(off_c), .phys(pa_c)
  );

  always_comb begin
    valid_d = in_valid;
    mem_d   = mem_op;
    off_d   = offset;
    seg_d   = seg_used;
    pa_d    = phys_addr;
    if (in_valid) begin
      mem_d = mem_c;
      off_d = mem_c ? off_c  : '0;
      seg_d = mem_c ? code_c : 2'd0;
      pa_d  = mem_c ? pa_c   : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mem_op    <= 1'b0;
      offset    <= '0;
      seg_used  <= 2'd0;
      phys_addr <= '0;
    end else begin
      out_valid <= valid_d;
      mem_op    <= mem_d;
      offset    <= off_d;
      seg_used  <= seg_d;
      phys_addr <= pa_d;
    end
  end
endmodule

// File: rtl/ea_addr_gen_chk.sv
module ea_addr_gen_chk #(
  parameter int unsigned OFF_W = 16,
  parameter int unsigned SEG_W = 16,
  parameter int unsigned SHIFT = 4,
  parameter int unsigned PA_W  = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       mode,
  input logic [OFF_W-1:0] disp,
  input logic             ovr_valid,
  input logic [1:0]       ovr_seg,
  input logic [SEG_W-1:0] seg_es,
  input logic [SEG_W-1:0] seg_cs,
  input logic [SEG_W-1:0] seg_ss,
  input logic [SEG_W-1:0] seg_ds,
  input logic             out_valid,
  input logic             mem_op,
  input logic [OFF_W-1:0] offset,
  input logic [1:0]       seg_used,
  input logic [PA_W-1:0]  phys_addr
);
  localparam int unsigned W = SEG_W + SHIFT + 1;

  logic [3:0][SEG_W-1:0] seg_q;
  logic [W-1:0]          pa_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seg_q <= '0;
    else if (in_valid) seg_q <= {seg_ds, seg_ss, seg_cs, seg_es};
  end

  assign pa_ref = (W'(seg_q[seg_used]) << SHIFT) + W'(offset);

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(phys_addr) && $stable(offset) && $stable(seg_used))); // R2
  AST_NOMEM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !mem_op) |-> (phys_addr == '0 && offset == '0 && seg_used == 2'd0)); // R3
  AST_DIRECT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd2) |=> (offset == $past(disp))); // R4
  AST_STR_ES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 3'd6) |=> (seg_used == 2'd0)); // R8
  AST_OVR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ovr_valid && mode >= 3'd2 && mode <= 3'd5) |=> (seg_used == $past(ovr_seg))); // R9
  AST_PA_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mem_op) |-> (phys_addr == pa_ref[PA_W-1:0])); // R11
endmodule

bind ea_addr_gen ea_addr_gen_chk #(.OFF_W(OFF_W), .SEG_W(SEG_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .disp(disp),
  .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
  .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
  .out_valid(out_valid), .mem_op(mem_op), .offset(offset), .seg_used(seg_used),
  .phys_addr(phys_addr)
);

// File: tb/ea_addr_gen_tb_top.sv
module ea_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  mode;
  logic [1:0]  ptr_sel, disp_sz, ovr_seg;
  logic [15:0] disp, reg_bx, reg_bp, reg_si, reg_di;
  logic [15:0] seg_es, seg_cs, seg_ss, seg_ds;
  logic        ovr_valid;
  logic        out_valid, mem_op;
  logic [15:0] offset;
  logic [1:0]  seg_used;
  logic [19:0] phys_addr;

  int checks = 0;
  int failures = 0;
  int e_val = 0, e_mem = 0, e_off = 0, e_seg = 0, e_pa = 0;
  string e_tag = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .ptr_sel(ptr_sel),
    .disp_sz(disp_sz), .disp(disp), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg),
    .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
    .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
    .out_valid(out_valid), .mem_op(mem_op), .offset(offset), .seg_used(seg_used),
    .phys_addr(phys_addr)
  );

  function automatic int pick(input int p);
    case (p)
      0: return reg_bx;
      1: return reg_bp;
      2: return reg_si;
      default: return reg_di;
    endcase
  endfunction

  function automatic int segv(input int c);
    case (c)
      0: return seg_es;
      1: return seg_cs;
      2: return seg_ss;
      default: return seg_ds;
    endcase
  endfunction

  // Behavioural reference: computes what the outputs must show after the next edge
  task automatic model();
    int dx, o, s, bp;
    if (!in_valid) begin
      e_val = 0;
      e_tag = "R2";
      return;
    end
    e_val = 1;
    dx = (disp_sz == 0) ? 0 :
         (disp_sz == 1) ? ((disp[7]) ? (int'(disp[7:0]) - 256) : int'(disp[7:0])) : int'(disp);
    bp = 0; o = 0; s = 3;
    case (mode)
      2: begin o = disp; e_tag = "R4"; end
      3: begin o = pick(ptr_sel); bp = (ptr_sel == 1); e_tag = "R5"; end
      4: begin o = pick(ptr_sel) + dx; bp = (ptr_sel == 1); e_tag = "R6"; end
      5: begin
        o = (ptr_sel[0] ? reg_bp : reg_bx) + (ptr_sel[1] ? reg_di : reg_si) + dx;
        bp = ptr_sel[0]; e_tag = "R7";
      end
      6: begin o = reg_di; e_tag = "R8"; end
      default: e_tag = "R3";
    endcase
    if (mode < 2 || mode == 7) begin
      e_mem = 0; e_off = 0; e_seg = 0; e_pa = 0;
      return;
    end
    o = o & 32'hFFFF;
    if (bp) s = 2;
    if (mode == 6) s = 0;
    else if (ovr_valid) begin s = ovr_seg; e_tag = "R9"; end
    e_mem = 1;
    e_off = o;
    e_seg = s;
    e_pa  = (segv(s) * 16 + o) & 32'hFFFFF;
  endtask

  task automatic cmp(input string tag);
    checks++;
    if (out_valid !== e_val[0] || mem_op !== e_mem[0] || offset !== e_off[15:0] ||
        seg_used !== e_seg[1:0] || phys_addr !== e_pa[19:0]) begin
      failures++;
      $display("FAIL %s: got v=%0b m=%0b off=%h seg=%0d pa=%h exp v=%0b m=%0b off=%h seg=%0d pa=%h",
               tag, out_valid, mem_op, offset, seg_used, phys_addr,
               e_val[0], e_mem[0], e_off[15:0], e_seg[1:0], e_pa[19:0]);
    end
  endtask

  task automatic step();
    model();
    @(posedge clk);
    @(negedge clk);
    cmp(e_tag);
  endtask

  task automatic req(input int m, input int p, input int dz, input int d, input int ov, input int os);
    in_valid = 1; mode = m[2:0]; ptr_sel = p[1:0]; disp_sz = dz[1:0]; disp = d[15:0];
    ovr_valid = ov[0]; ovr_seg = os[1:0];
    step();
  endtask

  task automatic idle();
    in_valid = 0;
    mode = 3'($urandom); disp = 16'($urandom);
    step();
  endtask

  initial begin
    rst_n = 0; in_valid = 0; mode = 0; ptr_sel = 0; disp_sz = 0; disp = 0;
    ovr_valid = 0; ovr_seg = 0;
    reg_bx = 16'h1000; reg_bp = 16'h2000; reg_si = 16'h0030; reg_di = 16'h0040;
    seg_es = 16'h4000; seg_cs = 16'h5000; seg_ss = 16'h6000; seg_ds = 16'h7000;
    repeat (3) @(negedge clk);
    cmp("R1");                          // R1 in reset
    rst_n = 1;
    @(negedge clk);
    cmp("R1");                          // R1 after release, no request yet

    req(2, 0, 0, 16'h1592, 0, 0);       // R4 direct, DS
    idle();                             // R2 hold
    req(0, 0, 0, 16'h1234, 0, 0);       // R3 register operand
    req(1, 0, 0, 16'h0005, 0, 0);       // R3 immediate
    req(7, 2, 2, 16'h0005, 1, 1);       // R3 reserved
    req(3, 1, 0, 16'hFFFF, 0, 0);       // R5 BP -> SS, disp ignored
    req(3, 2, 2, 16'h0100, 0, 0);       // R5 SI -> DS
    req(4, 0, 1, 16'h00FC, 0, 0);       // R6 negative 8-bit disp
    req(4, 3, 1, 16'hFF10, 0, 0);       // R6 positive 8-bit, high byte ignored
    req(4, 1, 2, 16'h8001, 0, 0);       // R6 16-bit disp with BP
    req(5, 1, 1, 16'h0080, 0, 0);       // R7 BP+SI-128 -> SS
    req(5, 2, 0, 16'h0000, 0, 0);       // R7 BX+DI -> DS
    req(6, 0, 2, 16'h7777, 1, 2);       // R8 string dst ignores override
    req(5, 1, 0, 0, 1, 3);              // R9 override on BP form -> DS
    req(2, 0, 0, 16'h0010, 1, 1);       // R9 override CS on direct
    reg_bx = 16'hFFFF; reg_si = 16'h0002;
    req(5, 0, 0, 0, 0, 0);              // R10 wrap -> 0001
    seg_ds = 16'hFFFF;
    req(2, 0, 0, 16'h0010, 0, 0);       // R11 wrap -> 00000
    idle(); idle();                     // R2 hold across idles

    for (int i = 0; i < 400; i++) begin
      reg_bx = 16'($urandom); reg_bp = 16'($urandom); reg_si = 16'($urandom); reg_di = 16'($urandom);
      seg_es = 16'($urandom); seg_cs = 16'($urandom); seg_ss = 16'($urandom); seg_ds = 16'($urandom);
      if (($urandom % 5) == 0) idle();
      else req($urandom % 8, $urandom % 4, $urandom % 4, $urandom, $urandom % 2, $urandom % 4);
    end
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got hung run expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule